// File: doc/BRIEF.md
# Monitor Channel Handshake Receiver

This block is the receiving end of a byte-wide monitor channel carried in a framed serial stream. A deserializer upstream presents, once per frame, the sender's MX handshake bit and the monitor byte. The block answers on the MR handshake bit. Both handshake bits are active low. The block stores each new byte, flags that the byte is available, and pulses an interrupt. It acknowledges the byte on MR only after the CPU has read it.

The first byte of a message is acknowledged by MR moving from inactive to active. Each later byte is acknowledged by MR going inactive for one frame and then active again. Two consecutive inactive MX frames end the message: the block pulses an end-of-message interrupt and returns MR to inactive. If the sender presents a new byte before the CPU has taken the previous one, the block flags an overrun and requests an abort. It does this by holding MR inactive for at least `ABORT_FRAMES` frames and until the sender closes the message.

Top module: `monitor_rx`

## Requirements
- R1: After reset `mr_o`=1, and `rx_avail_o`, `rx_irq_o`, `eom_irq_o`, `overrun_o` and `abort_o` are all 0.
- R2: While idle, `mr_o` is 1. A frame with `mx_i`=0 that follows a frame with `mx_i`=1 starts a message. It stores `mon_data_i` into `rx_data_o`, sets `rx_avail_o`, and pulses `rx_irq_o` for one cycle after the frame edge.
- R3: `mr_o` does not go active for a byte until `rd_i` has been seen while `rx_avail_o`=1. That read clears `rx_avail_o`. A read while `rx_avail_o`=0 changes no output.
- R4: For the first byte of a message, the first frame strobe after the read drives `mr_o` to 0.
- R5: For every later byte, the acknowledge is `mr_o`=1 at the first frame strobe after the read and `mr_o`=0 at the next strobe. `mr_o` changes only on frame strobes.
- R6: During a message, a new byte is taken only when `mx_i`=0 follows exactly one frame with `mx_i`=1. Consecutive frames with `mx_i`=0 add no byte.
- R7: During a message, two consecutive frames with `mx_i`=1 pulse `eom_irq_o` and set `mr_o`=1, and the block returns to idle. A single inactive frame ends nothing.
- R8: A new byte arriving while `rx_avail_o`=1 sets `overrun_o` and `abort_o`. The stored byte is kept, and `mr_o` becomes 1.
- R9: During an abort, `mr_o` stays 1. The abort ends, with an `eom_irq_o` pulse, at the first two-inactive-MX frame on which at least `ABORT_FRAMES` frames have been counted since the abort began.
- R10: `overrun_o` stays set until the next message starts, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe: MX and byte of a frame are valid |
| mx_i | input | 1 | Sender handshake bit, 0 = active |
| mon_data_i | input | DW | Monitor byte of the frame |
| rd_i | input | 1 | CPU read of the receive data register |
| mr_o | output | 1 | Receiver handshake bit, 0 = active |
| rx_data_o | output | DW | Receive data register |
| rx_avail_o | output | 1 | Stored byte not yet read |
| rx_irq_o | output | 1 | Pulse: new byte stored |
| eom_irq_o | output | 1 | Pulse: message ended |
| overrun_o | output | 1 | Byte arrived before the previous one was read |
| abort_o | output | 1 | Abort request in progress |

## Verification
The hardest state to reach is an abort that must outlast the sender. This needs an overrun inside a message that has already delivered and acknowledged a byte. The sender must then keep MX active for several frames, so the abort is held past its minimum. A CPU read during the abort must also not produce an acknowledge. The stimulus gets there by delivering and acknowledging a byte, sending one inactive frame, and then presenting a second byte with no read in between. It then issues a read before letting MX go inactive twice. A reference model, stepped every clock, shadows all outputs throughout.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MSG   = 2'd1,
    ST_ABORT = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic frame;  // strobe of this cycle
    logic fall;   // MX active after an inactive frame
    logic eom;    // second consecutive inactive frame
  } frame_evt_t;
endpackage

// File: rtl/mon_rx_detect.sv
module mon_rx_detect
  import mon_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic       mx_i,
  output frame_evt_t evt_o
);
  logic mx_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mx_prev_q <= 1'b1;
    else if (frame_i) mx_prev_q <= mx_i;
  end

  always_comb begin
    evt_o.frame = frame_i;
    evt_o.fall  = frame_i & ~mx_i & mx_prev_q;
    evt_o.eom   = frame_i & mx_i & mx_prev_q;
  end
endmodule

// File: rtl/mon_rx_ctl.sv
module mon_rx_ctl
  import mon_rx_pkg::*;
#(
  parameter int ABORT_FRAMES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  frame_evt_t evt_i,
  input  logic       avail_i,
  output rx_state_e  state_o,
  output rx_state_e  state_next_o,
  output logic       latch_o,
  output logic       eom_irq_o,
  output logic       overrun_o,
  output logic       abort_o
);
  localparam int CNT_W = $clog2(ABORT_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ABORT_FRAMES);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             eom_p, ovr_set, eom_q, ovr_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    latch_o = 1'b0;
    eom_p   = 1'b0;
    ovr_set = 1'b0;
    if (evt_i.frame) begin
      unique case (state_q)
        ST_IDLE: if (evt_i.fall) begin
          state_d = ST_MSG;
          latch_o = 1'b1;
        end
        ST_MSG: begin
          if (evt_i.fall) begin
            if (avail_i) begin
              state_d = ST_ABORT;
              ovr_set = 1'b1;
              cnt_d   = '0;
            end else begin
              latch_o = 1'b1;
            end
          end else if (evt_i.eom) begin
            state_d = ST_IDLE;
            eom_p   = 1'b1;
          end
        end
        ST_ABORT: begin
          if (cnt_q < CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
          if (evt_i.eom && cnt_d >= CNT_MAX) begin
            state_d = ST_IDLE;
            eom_p   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      eom_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      eom_q   <= eom_p;
      if (latch_o && state_q == ST_IDLE) ovr_q <= 1'b0;
      else if (ovr_set)                  ovr_q <= 1'b1;
    end
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;
  assign eom_irq_o    = eom_q;
  assign overrun_o    = ovr_q;
  assign abort_o      = (state_q == ST_ABORT);

  assert_overrun_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> abort_o);
  assert_abort_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(abort_o) |-> eom_irq_o);
endmodule

// File: rtl/mon_rx_buf.sv
module mon_rx_buf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic [DW-1:0] mon_data_i,
  input  logic          rd_i,
  input  logic          in_msg_i,
  output logic [DW-1:0] data_o,
  output logic          avail_o,
  output logic          irq_o,
  output logic          ack_set_o
);
  logic [DW-1:0] data_q;
  logic          avail_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      avail_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= latch_i;
      if (latch_i) begin
        data_q  <= mon_data_i;
        avail_q <= 1'b1;
      end else if (rd_i) begin
        avail_q <= 1'b0;
      end
    end
  end

  // only reads of live data during a message earn an acknowledge
  assign ack_set_o = rd_i & avail_q & in_msg_i;
  assign data_o    = data_q;
  assign avail_o   = avail_q;
  assign irq_o     = irq_q;

  assert_irq_avail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> avail_q);
endmodule

// File: rtl/mon_rx_ack.sv
module mon_rx_ack
  import mon_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      frame_i,
  input  rx_state_e state_i,
  input  rx_state_e state_next_i,
  input  logic      ack_set_i,
  output logic      mr_o
);
  logic mr_q, mr_d, req_q, req_d;

  always_comb begin
    mr_d  = mr_q;
    req_d = req_q | ack_set_i;
    if (frame_i) begin
      if (state_next_i != ST_MSG) begin
        mr_d  = 1'b1;
        req_d = 1'b0;
      end else if (req_q) begin
        if (!mr_q) begin
          mr_d = 1'b1;          // inactive gap before re-activation
        end else begin
          mr_d  = 1'b0;
          req_d = ack_set_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr_q  <= 1'b1;
      req_q <= 1'b0;
    end else begin
      mr_q  <= mr_d;
      req_q <= req_d;
    end
  end

  assign mr_o = mr_q;

  assert_mr_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_MSG) |-> mr_q);
  assert_mr_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mr_q) |-> $past(req_q));
  assert_mr_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mr_q) |-> $past(frame_i));
endmodule

// File: rtl/monitor_rx.sv
module monitor_rx
  import mon_rx_pkg::*;
#(
  parameter int DW           = 8,
  parameter int ABORT_FRAMES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          mx_i,
  input  logic [DW-1:0] mon_data_i,
  input  logic          rd_i,
  output logic          mr_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_avail_o,
  output logic          rx_irq_o,
  output logic          eom_irq_o,
  output logic          overrun_o,
  output logic          abort_o
);
  frame_evt_t evt;
  rx_state_e  state, state_next;
  logic       latch, ack_set;

  mon_rx_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .mx_i   (mx_i),
    .evt_o  (evt)
  );

  mon_rx_ctl #(.ABORT_FRAMES(ABORT_FRAMES)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .avail_i     (rx_avail_o),
    .state_o     (state),
    .state_next_o(state_next),
    .latch_o     (latch),
    .eom_irq_o   (eom_irq_o),
    .overrun_o   (overrun_o),
    .abort_o     (abort_o)
  );

  mon_rx_buf #(.DW(DW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_i   (latch),
    .mon_data_i(mon_data_i),
    .rd_i      (rd_i),
    .in_msg_i  (state == ST_MSG),
    .data_o    (rx_data_o),
    .avail_o   (rx_avail_o),
    .irq_o     (rx_irq_o),
    .ack_set_o (ack_set)
  );

  mon_rx_ack u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_i),
    .state_i     (state),
    .state_next_i(state_next),
    .ack_set_i   (ack_set),
    .mr_o        (mr_o)
  );
endmodule

// File: tb/monitor_rx_test.sv
`timescale 1ns/1ps
module monitor_rx_test;
  localparam int DW = 8;
  localparam int AB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame = 1'b0;
  logic          mx = 1'b1;
  logic [DW-1:0] din = '0;
  logic          rd = 1'b0;
  logic          mr, avail, rxirq, eomirq, ovr, abrt;
  logic [DW-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  monitor_rx #(.DW(DW), .ABORT_FRAMES(AB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .mx_i(mx), .mon_data_i(din),
    .rd_i(rd), .mr_o(mr), .rx_data_o(dout), .rx_avail_o(avail), .rx_irq_o(rxirq),
    .eom_irq_o(eomirq), .overrun_o(ovr), .abort_o(abrt)
  );

  // reference model: 0 idle, 1 message, 2 abort
  int m_st, m_prev, m_mr, m_ack, m_av, m_data, m_ovr, m_cnt, m_rxirq, m_eom;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_prev = 1; m_mr = 1; m_ack = 0; m_av = 0; m_data = 0;
      m_ovr = 0; m_cnt = 0; m_rxirq = 0; m_eom = 0;
    end else begin
      int was_av, want_ack;
      was_av = m_av;
      want_ack = 0;
      m_rxirq = 0;
      m_eom = 0;
      if (rd && m_av) begin
        if (m_st == 1) want_ack = 1;
      end
      if (frame) begin
        bit fall, two_idle;
        fall = (mx == 0) && (m_prev == 1);
        two_idle = (mx == 1) && (m_prev == 1);
        if (m_st == 0) begin
          if (fall) begin m_st = 1; m_data = din; m_av = 1; m_rxirq = 1; m_ovr = 0; end
        end else if (m_st == 1) begin
          if (fall) begin
            if (was_av) begin m_st = 2; m_ovr = 1; m_cnt = 0; end
            else begin m_data = din; m_av = 1; m_rxirq = 1; end
          end else if (two_idle) begin
            m_st = 0; m_eom = 1;
          end
        end else begin
          if (m_cnt < AB) m_cnt++;
          if (two_idle && m_cnt >= AB) begin m_st = 0; m_eom = 1; end
        end
        if (m_st != 1) begin m_mr = 1; m_ack = 0; want_ack = 0; end
        else if (m_ack == 1) begin
          if (m_mr == 0) m_mr = 1;
          else begin m_mr = 0; m_ack = 0; end
        end
        m_prev = mx;
      end
      if (rd && was_av && !(frame && m_rxirq == 1)) m_av = 0;
      if (want_ack) m_ack = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5", "mr_o", mr, m_mr);
      chk("R2", "rx_data_o", dout, m_data);
      chk("R3", "rx_avail_o", avail, m_av);
      chk("R2", "rx_irq_o", rxirq, m_rxirq);
      chk("R7", "eom_irq_o", eomirq, m_eom);
      chk("R8", "overrun_o", ovr, m_ovr);
      chk("R9", "abort_o", abrt, m_st == 2);
    end
  end

  // one frame of four cycles; optional CPU read in the middle
  task automatic send(input logic x, input int d, input bit do_rd);
    @(negedge clk); frame = 1'b1; mx = x; din = DW'(d);
    @(negedge clk); frame = 1'b0; rd = do_rd;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "mr_o", mr, 1);
    chk("R1", "flags", {avail, rxirq, eomirq, ovr, abrt}, 0);
    // R3: read with nothing stored
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    chk("R3", "idle read mr/avail", {mr, avail}, 2'b10);
    send(1, 0, 0); send(1, 0, 0);
    // R2: message start
    send(0, 8'hA1, 0);
    // R3: no ack before the read
    send(0, 8'hA1, 0); send(0, 8'hA1, 1);
    // R4: first ack
    send(0, 8'hA1, 0);
    chk("R4", "mr after first ack", mr, 0);
    // R7: single inactive frame is not end of message
    send(1, 8'h00, 0);
    chk("R7", "abort/eom after single idle", {eomirq, abrt}, 0);
    // R6: next byte after exactly one inactive frame
    send(0, 8'hB2, 1);
    // R5: inactive-then-active acknowledge
    send(0, 8'hB2, 0);
    chk("R5", "mr gap", mr, 1);
    send(0, 8'hC3, 0);
    chk("R5", "mr re-active", mr, 0);
    // R6: held-active MX frames add no byte
    send(0, 8'hD4, 0); send(0, 8'hD5, 0);
    chk("R6", "data unchanged", dout, 8'hB2);
    // R7: end of message
    send(1, 0, 0); send(1, 0, 0);
    send(1, 0, 0);
    // R8: overrun in second message
    send(0, 8'h11, 1); send(0, 8'h11, 0);
    send(1, 0, 0);
    send(0, 8'h22, 0);
    send(1, 0, 0);
    send(0, 8'h33, 0);
    chk("R8", "byte kept", dout, 8'h22);
    // R9: abort outlasts sender; read during abort yields no ack
    send(0, 8'h44, 1); send(0, 8'h44, 0); send(0, 8'h44, 0);
    chk("R9", "mr held inactive", mr, 1);
    send(1, 0, 0); send(1, 0, 0); send(1, 0, 0);
    chk("R9", "abort cleared", abrt, 0);
    // R10: overrun cleared by next message
    send(0, 8'h55, 0);
    chk("R10", "overrun cleared", ovr, 0);
    send(0, 8'h55, 1); send(0, 8'h55, 0);
    send(1, 0, 0); send(1, 0, 0); send(1, 0, 0);
    // immediate close after overrun
    send(0, 8'h66, 0); send(1, 0, 0); send(0, 8'h77, 0);
    send(1, 0, 0); send(1, 0, 0); send(1, 0, 0);
    chk("R9", "idle after short abort", {abrt, mr}, 2'b01);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule